// File: doc/BRIEF.md
# Not-Recently-Used Way Selector

This unit picks the way to evict in a set-associative cache. For every set it holds one flag bit per way. A flag at one means the way has not been used since the set's flags were last refreshed. A hit or a fill into a way is reported as a touch, and the touch clears that way's flag. If a touch would leave every flag of the set at zero, the whole set is refreshed to all ones instead, so each set always keeps at least one candidate.

When the cache controller needs a victim, it raises a request together with the set index. In the same cycle the unit returns the lowest-numbered way whose flag is still one, along with a valid flag. The choice is decoded combinationally from the stored flags. Flag updates take effect on the next rising clock edge. A fill into the returned way is reported as an ordinary touch, either in the same cycle as the request or later. Tags, data and miss tracking are kept elsewhere. The number of sets and ways are parameters.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset is released, every flag of every set is one, so a request to any set returns way 0 with valid high.
- R2: A touch clears the flag of the addressed way in the addressed set at the next clock edge, as long as some other flag of that set is still one.
- R3: A touch that would leave all flags of its set at zero instead writes every flag of that set to one, including the flag of the touched way.
- R4: The returned way always has its flag at one. No lower-numbered way of the same set has its flag at one.
- R5: victim_valid_o is high exactly in the cycles where victim_req_i is high. victim_way_o has meaning only while victim_valid_o is high.
- R6: The returned way reflects the flags stored before the current cycle's edge. A touch to the same set in the same cycle does not change the answer until the following cycle.
- R7: Flags of sets other than the touched one never change. A cycle with no touch changes no flag, and a request by itself changes no flag.
- R8: Touching a way whose flag is already zero leaves the set's flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | SET_W | Set index for both the touch and the request |
| touch_i | input | 1 | Hit or fill strobe for way touch_way_i |
| touch_way_i | input | WAY_W | Way being touched |
| victim_req_i | input | 1 | Victim request strobe |
| victim_way_o | output | WAY_W | Way chosen for eviction |
| victim_valid_o | output | 1 | Qualifies victim_way_o |

## Verification
A victim request and a touch can arrive in the same cycle on the same set. This is the case where a fill goes into the way that was just chosen. The bench provokes it with directed steps and also through random traffic that is confined to a few sets. The expected victim is computed from the bench model's flags before that cycle's update, so the answer must not show the touch until the next cycle. The bench then checks in the following cycle that the touch has been applied, including when it causes a refresh.

// File: rtl/nru_pkg.sv
package nru_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nru_state_array.sv
module nru_state_array #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 8,
  localparam int unsigned SET_W = nru_pkg::idx_w(SETS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SET_W-1:0]       rd_set_i,
  output logic [WAYS-1:0]        rd_bits_o,
  input  logic                   wr_en_i,
  input  logic [SET_W-1:0]       wr_set_i,
  input  logic [WAYS-1:0]        wr_bits_i,
  output logic [SETS*WAYS-1:0]   state_o
);
  logic [WAYS-1:0] rows_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        rows_q[s] <= '1;
      else if (wr_en_i && (wr_set_i == SET_W'(s)))
        rows_q[s] <= wr_bits_i;
    end
    assign state_o[s*WAYS +: WAYS] = rows_q[s];
  end

  always_comb begin
    rd_bits_o = '1;
    for (int s = 0; s < SETS; s++)
      if (rd_set_i == SET_W'(s)) rd_bits_o = rows_q[s];
  end
endmodule

// File: rtl/nru_next_bits.sv
module nru_next_bits #(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned WAY_W = nru_pkg::idx_w(WAYS)
) (
  input  logic [WAYS-1:0]  cur_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAYS-1:0]  next_o,
  output logic             refresh_o
);
  logic [WAYS-1:0] hit_oh;
  logic [WAYS-1:0] cleared;

  always_comb begin
    for (int w = 0; w < WAYS; w++) hit_oh[w] = (way_i == WAY_W'(w));
    cleared   = cur_i & ~hit_oh;
    refresh_o = (cleared == '0);
    next_o    = refresh_o ? '1 : cleared;
  end
endmodule

// File: rtl/nru_lowest_pick.sv
module nru_lowest_pick #(
  parameter int unsigned WAYS  = 8,
  localparam int unsigned WAY_W = nru_pkg::idx_w(WAYS)
) (
  input  logic [WAYS-1:0]  bits_i,
  output logic [WAY_W-1:0] way_o,
  output logic             any_o
);
  // descending scan: last assignment wins, giving the lowest set bit
  always_comb begin
    way_o = '0;
    any_o = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (bits_i[w]) begin
        way_o = WAY_W'(w);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned SET_W = nru_pkg::idx_w(NUM_SETS),
  localparam int unsigned WAY_W = nru_pkg::idx_w(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic             victim_req_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic             victim_valid_o
);
  logic [NUM_WAYS-1:0]          cur_bits;
  logic [NUM_WAYS-1:0]          new_bits;
  logic [NUM_SETS*NUM_WAYS-1:0] state_flat;
  logic                         refresh;
  logic                         any_cand;

  nru_state_array #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_set_i  (set_i),
    .rd_bits_o (cur_bits),
    .wr_en_i   (touch_i),
    .wr_set_i  (set_i),
    .wr_bits_i (new_bits),
    .state_o   (state_flat)
  );

  nru_next_bits #(.WAYS(NUM_WAYS)) u_next (
    .cur_i     (cur_bits),
    .way_i     (touch_way_i),
    .next_o    (new_bits),
    .refresh_o (refresh)
  );

  nru_lowest_pick #(.WAYS(NUM_WAYS)) u_pick (
    .bits_i (cur_bits),
    .way_o  (victim_way_o),
    .any_o  (any_cand)
  );

  assign victim_valid_o = victim_req_i & any_cand;

  logic unused_refresh;
  assign unused_refresh = refresh;
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 8,
  localparam int unsigned SET_W = nru_pkg::idx_w(SETS),
  localparam int unsigned WAY_W = nru_pkg::idx_w(WAYS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SET_W-1:0]     set_i,
  input logic                 touch_i,
  input logic [WAY_W-1:0]     touch_way_i,
  input logic                 victim_req_i,
  input logic [WAY_W-1:0]     victim_way_o,
  input logic                 victim_valid_o,
  input logic [SETS*WAYS-1:0] state_i
);
  logic [WAYS-1:0]  cur, t_oh, v_oh, below, prow, p_oh;
  logic [SET_W-1:0] p_set;
  logic [WAY_W-1:0] p_way;
  logic             p_clear, p_refresh, p_noop;
  logic [WAYS-1:0]  p_cur;

  always_comb begin
    cur  = '1;
    prow = '1;
    for (int s = 0; s < SETS; s++) begin
      if (set_i == SET_W'(s)) cur  = state_i[s*WAYS +: WAYS];
      if (p_set == SET_W'(s)) prow = state_i[s*WAYS +: WAYS];
    end
    for (int w = 0; w < WAYS; w++) begin
      t_oh[w]  = (touch_way_i == WAY_W'(w));
      v_oh[w]  = (victim_way_o == WAY_W'(w));
      p_oh[w]  = (p_way == WAY_W'(w));
      below[w] = (WAY_W'(w) < victim_way_o);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_set <= '0; p_way <= '0; p_cur <= '1;
      p_clear <= 1'b0; p_refresh <= 1'b0; p_noop <= 1'b0;
    end else begin
      p_set     <= set_i;
      p_way     <= touch_way_i;
      p_cur     <= cur;
      p_clear   <= touch_i && ((cur & ~t_oh) != '0);
      p_refresh <= touch_i && ((cur & ~t_oh) == '0);
      p_noop    <= touch_i && ((cur & t_oh) == '0);
    end
  end

  a_r2_touch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_clear |-> ((prow & p_oh) == '0));
  a_r3_refresh_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_refresh |-> (prow == '1));
  a_r3_never_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur != '0);
  a_r4_victim_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> ((cur & v_oh) != '0));
  a_r4_victim_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> ((cur & below) == '0));
  a_r5_valid_tracks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o == victim_req_i);
  a_r7_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch_i |=> $stable(state_i));
  a_r8_zero_touch_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_noop |-> (prow == p_cur));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .set_i          (set_i),
  .touch_i        (touch_i),
  .touch_way_i    (touch_way_i),
  .victim_req_i   (victim_req_i),
  .victim_way_o   (victim_way_o),
  .victim_valid_o (victim_valid_o),
  .state_i        (state_flat)
);

// File: tb/sim_nru_victim_sel.sv
module sim_nru_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int SETS  = 16;
  localparam int WAYS  = 4;
  localparam int SET_W = 4;
  localparam int WAY_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SET_W-1:0] set_s = '0;
  logic             touch = 1'b0;
  logic [WAY_W-1:0] tway = '0;
  logic             req = 1'b0;
  logic [WAY_W-1:0] vway;
  logic             vvalid;

  int checks = 0;
  int fails  = 0;
  logic [WAYS-1:0] model [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  nru_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .touch_i(touch),
    .touch_way_i(tway), .victim_req_i(req),
    .victim_way_o(vway), .victim_valid_o(vvalid)
  );

  function automatic int lowest(input logic [WAYS-1:0] b);
    for (int w = 0; w < WAYS; w++) if (b[w]) return w;
    return -1;
  endfunction

  function automatic logic [WAYS-1:0] after_touch(input logic [WAYS-1:0] b, input int w);
    logic [WAYS-1:0] c;
    c = b;
    c[w] = 1'b0;
    return (c == '0) ? '1 : c;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // one cycle: drive at negedge, judge before the edge, update model after it
  task automatic step(input int s, input bit t, input int w, input bit r, input string rq);
    @(negedge clk);
    set_s = SET_W'(s); touch = t; tway = WAY_W'(w); req = r;
    #1;
    check(vvalid == r, {rq, " valid"}, int'(vvalid), int'(r));
    if (r) check(int'(vway) == lowest(model[s]), {rq, " way"}, int'(vway), lowest(model[s]));
    @(posedge clk);
    if (t) model[s] = after_touch(model[s], w);
  endtask

  task automatic probe(input int s, input string rq);
    step(s, 1'b0, 0, 1'b1, rq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < SETS; s++) model[s] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < SETS; s++) probe(s, "R1");
    // R5: no request, no valid
    step(0, 1'b0, 0, 1'b0, "R5");

    // R2: touch clears flag
    step(3, 1'b1, 0, 1'b0, "R2");
    probe(3, "R2");
    check(vway == 1, "R2 after touch", int'(vway), 1);
    // R7: other set untouched, request has no side effect
    probe(4, "R7");
    probe(3, "R7");
    probe(3, "R7");
    // R8: touch of cleared way
    step(3, 1'b1, 0, 1'b0, "R8");
    probe(3, "R8");
    check(vway == 1, "R8 victim", int'(vway), 1);
    // R6: same-cycle request and fill into chosen way
    step(3, 1'b1, 1, 1'b1, "R6");
    probe(3, "R6");
    check(vway == 2, "R6 next cycle", int'(vway), 2);
    step(3, 1'b1, 2, 1'b1, "R6");
    probe(3, "R4");
    check(vway == 3, "R4 last candidate", int'(vway), 3);
    // R3: emptying touch refreshes set
    step(3, 1'b1, 3, 1'b1, "R3");
    probe(3, "R3");
    check(vway == 0, "R3 refresh", int'(vway), 0);
    // R4: non-contiguous pattern
    step(5, 1'b1, 0, 1'b0, "R4");
    step(5, 1'b1, 2, 1'b0, "R4");
    probe(5, "R4");
    step(5, 1'b1, 1, 1'b0, "R4");
    probe(5, "R4");
    check(vway == 3, "R4 gap", int'(vway), 3);

    // random traffic, mostly on a few sets to force refreshes and collisions
    for (int i = 0; i < 4000; i++) begin
      int s;
      s = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, SETS-1)) : int'($urandom_range(0, 2));
      step(s, 1'($urandom_range(0, 1)), int'($urandom_range(0, WAYS-1)),
           1'($urandom_range(0, 1)), "R6 random");
    end
    // R7: all sets match model after random run
    for (int s = 0; s < SETS; s++) probe(s, "R7 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule